// File: doc/BRIEF.md
# UART Self-Test Interrupt and Loopback Controller

This block is the register-level control core of a byte-oriented UART, reduced to the parts that serve self-test. A CPU reaches six registers over a simple single-cycle bus: receive/transmit data, interrupt enable, interrupt identification, modem control, line status and modem status. Serial shifting is outside the block. The transmit side is a byte handshake (valid/ready) and the receive side is a byte strobe that carries error flags.

Setting the loopback bit sends each byte written for transmission straight back into the receive buffer. While loopback is on, the transmit handshake stays idle, the modem control outputs stay inactive, and the external receive strobe and modem pins are cut off. In this mode software can write the line status and modem status registers directly. Those writes act as real events and raise interrupts, so error-handling code can be exercised without a faulty line. One interrupt line reports the highest-priority enabled cause. The identification register gives the cause as a code.

Top module: `uart_selftest_ctrl`

## Requirements
- R1: Register offsets are data 0, interrupt enable 1, identification 2, modem control 3, line status 4, modem status 5. After reset, identification reads 0x01, line status reads 0x20, interrupt enable and modem control read 0x00, and irq_o and tx_valid are low.
- R2: Modem control bit 4 selects loopback. In loopback, a byte written to offset 0 appears in the receive buffer with line status bit 0 set. tx_valid stays low, dtr_o and rts_o stay low, and rx_valid and modem_in have no effect.
- R3: Line status bits are: 0 data ready, 1 overrun, 2 parity error, 3 framing error, 4 break, 5 transmit holding empty. A byte that arrives while data ready is set also sets overrun. Reading offset 0 clears data ready. Reading line status clears bits 4:1.
- R4: Outside loopback, a write to offset 0 clears bit 5 and raises tx_valid with tx_data equal to the byte. A cycle with tx_valid and tx_ready both high sets bit 5 again and drops tx_valid.
- R5: Identification bit 0 is 0 while a cause is pending and 1 otherwise. Bits 2:1 hold the cause: 3 line status, 2 received data, 1 transmit holding empty, 0 modem status. So the readings are 0x06, 0x04, 0x02 and 0x00.
- R6: Interrupt enable bit 2 gates line status errors, bit 0 gates data ready, bit 1 gates transmit-empty and bit 3 gates modem deltas. The priority order is line status, then received data, then transmit-empty, then modem status.
- R7: The transmit-empty cause is raised when bit 5 goes from 0 to 1. It is cleared by a read of the identification register that returns code 1, or by bit 5 falling.
- R8: Modem status bits 7:4 mirror modem_in[3:0]. Bits 3:0 are deltas: set on any change of the matching pin, except modem_in[2], which sets its delta only on a 1-to-0 change. Reading modem status clears the deltas.
- R9: In loopback, a line status write loads bits 5:0 from the written byte and raises interrupts as real events would. Writing 0x02 with bit 2 enabled gives identification 0x06 and line status 0x02.
- R10: In loopback, a modem status write loads all 8 bits. A written delta raises the modem cause.
- R11: Outside loopback, writes to line status and modem status change nothing.
- R12: irq_o is high only when a cause is pending, modem control bit 3 is set and loopback is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Bus access strobe, one cycle per access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed register |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error with the received byte |
| rx_ferr | input | 1 | Framing error with the received byte |
| rx_brk | input | 1 | Break with the received byte |
| modem_in | input | 4 | Modem inputs: clear-to-send, data-set-ready, ring, carrier |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences cover each real event path: received bytes with and without errors, back-to-back receives that overrun, a transmit handshake, and pin changes that include a rising and a falling ring. These show that real events and injected writes set the same status bits. A loopback echo separates internal return from the external paths. Stray receive strobes and pin changes sent during loopback must leave the state unchanged. Random enable masks combined with random injected line and modem status values test the priority and enable gating across many mixes of pending causes. Reads of the identification register check that the transmit-empty cause is cleared only when its own code is read.

// File: rtl/ust_pkg.sv
package ust_pkg;
   localparam int REG_AW = 3;

   // register offsets
   localparam logic [REG_AW-1:0] OFS_DATA = 3'd0;
   localparam logic [REG_AW-1:0] OFS_IEN  = 3'd1;
   localparam logic [REG_AW-1:0] OFS_IID  = 3'd2;
   localparam logic [REG_AW-1:0] OFS_MCTL = 3'd3;
   localparam logic [REG_AW-1:0] OFS_LST  = 3'd4;
   localparam logic [REG_AW-1:0] OFS_MST  = 3'd5;

   // line status bit positions
   localparam int LS_DR   = 0;
   localparam int LS_OE   = 1;
   localparam int LS_PE   = 2;
   localparam int LS_FE   = 3;
   localparam int LS_BI   = 4;
   localparam int LS_THRE = 5;
   localparam int LS_W    = 6;

   // modem control bit positions
   localparam int MC_DTR  = 0;
   localparam int MC_RTS  = 1;
   localparam int MC_OUT2 = 3;
   localparam int MC_LOOP = 4;
   localparam int MC_W    = 5;

   // interrupt enable bit positions
   localparam int IE_RXD  = 0;
   localparam int IE_THR  = 1;
   localparam int IE_LINE = 2;
   localparam int IE_MDM  = 3;
   localparam int IE_W    = 4;

   // priority slots, index 0 wins
   localparam int NSRC     = 4;
   localparam int SLOT_LN  = 0;
   localparam int SLOT_RX  = 1;
   localparam int SLOT_TH  = 2;
   localparam int SLOT_MD  = 3;
endpackage

// File: rtl/ust_prio.sv
module ust_prio #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   generate
      if (N < 2) begin : g_bad
         $error("ust_prio needs at least two sources");
      end
      for (genvar i = 0; i < N; i++) begin : g_slot
         assign grant[i]  = req[i] & ~seen[i];
         assign seen[i+1] = seen[i] | req[i];
      end
   endgenerate

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/ust_line.sv
module ust_line
   import ust_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          loop,
   input  logic          wr_data,
   input  logic          rd_data,
   input  logic          wr_lst,
   input  logic          rd_lst,
   input  logic [DW-1:0] wdata,
   input  logic          clr_thr,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_perr,
   input  logic          rx_ferr,
   input  logic          rx_brk,
   input  logic          tx_ready,
   output logic          tx_valid,
   output logic [DW-1:0] tx_data,
   output logic [DW-1:0] rbuf,
   output logic [LS_W-1:0] lst,
   output logic          thr_evt
);
   generate
      if (DW < LS_W) begin : g_bad
         $error("data width too small for line status");
      end
   endgenerate

   logic [LS_W-1:0] lst_q, lst_d;
   logic [DW-1:0]   hold_q, hold_d, rbuf_q, rbuf_d;
   logic            full_q, full_d, evt_q, evt_d;

   assign tx_valid = full_q & ~loop;
   assign tx_data  = hold_q;
   assign rbuf     = rbuf_q;
   assign lst      = lst_q;
   assign thr_evt  = evt_q;

   always_comb begin
      lst_d  = lst_q;
      hold_d = hold_q;
      rbuf_d = rbuf_q;
      full_d = full_q;
      if (rd_data) lst_d[LS_DR] = 1'b0;
      if (rd_lst)  lst_d[LS_BI:LS_OE] = '0;
      if (full_q && loop) begin
         rbuf_d = hold_q;
         if (lst_q[LS_DR] && !rd_data) lst_d[LS_OE] = 1'b1;
         lst_d[LS_DR]   = 1'b1;
         lst_d[LS_THRE] = 1'b1;
         full_d = 1'b0;
      end else if (tx_valid && tx_ready) begin
         lst_d[LS_THRE] = 1'b1;
         full_d = 1'b0;
      end
      if (!loop && rx_valid) begin
         rbuf_d = rx_data;
         if (lst_q[LS_DR] && !rd_data) lst_d[LS_OE] = 1'b1;
         lst_d[LS_DR] = 1'b1;
         lst_d[LS_PE] = lst_d[LS_PE] | rx_perr;
         lst_d[LS_FE] = lst_d[LS_FE] | rx_ferr;
         lst_d[LS_BI] = lst_d[LS_BI] | rx_brk;
      end
      if (wr_data) begin
         hold_d = wdata;
         full_d = 1'b1;
         lst_d[LS_THRE] = 1'b0;
      end
      if (wr_lst && loop) lst_d = wdata[LS_W-1:0];

      if (!lst_d[LS_THRE])     evt_d = 1'b0;
      else if (!lst_q[LS_THRE]) evt_d = 1'b1;
      else if (clr_thr)         evt_d = 1'b0;
      else                      evt_d = evt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lst_q  <= LS_W'(1) << LS_THRE;
         hold_q <= '0;
         rbuf_q <= '0;
         full_q <= 1'b0;
         evt_q  <= 1'b0;
      end else begin
         lst_q  <= lst_d;
         hold_q <= hold_d;
         rbuf_q <= rbuf_d;
         full_q <= full_d;
         evt_q  <= evt_d;
      end
   end
endmodule

// File: rtl/ust_modem.sv
module ust_modem #(
   parameter int MW     = 4,
   parameter int RI_BIT = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            loop,
   input  logic [MW-1:0]   pins,
   input  logic            wr_mst,
   input  logic            rd_mst,
   input  logic [2*MW-1:0] wdata,
   output logic [2*MW-1:0] mst
);
   logic [MW-1:0] lvl_q, dlt_q, chg;

   generate
      if (RI_BIT >= MW) begin : g_bad
         $error("ring bit outside modem width");
      end
      for (genvar i = 0; i < MW; i++) begin : g_dlt
         if (i == RI_BIT) begin : g_trail
            assign chg[i] = lvl_q[i] & ~pins[i];
         end else begin : g_any
            assign chg[i] = lvl_q[i] ^ pins[i];
         end
      end
   endgenerate

   assign mst = {lvl_q, dlt_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         dlt_q <= '0;
      end else if (loop) begin
         if (wr_mst) begin
            lvl_q <= wdata[2*MW-1:MW];
            dlt_q <= wdata[MW-1:0];
         end else if (rd_mst) begin
            dlt_q <= '0;
         end
      end else begin
         lvl_q <= pins;
         dlt_q <= (rd_mst ? '0 : dlt_q) | chg;
      end
   end
endmodule

// File: rtl/uart_selftest_ctrl.sv
module uart_selftest_ctrl
   import ust_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MDM_W  = 4,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              rx_brk,
   input  logic [MDM_W-1:0]  modem_in,
   output logic              dtr_o,
   output logic              rts_o,
   output logic              irq_o
);
   localparam int IW = $clog2(NSRC);

   generate
      if (DATA_W != 8) begin : g_dw
         $error("register layout assumes 8-bit data");
      end
      if (2 * MDM_W != DATA_W) begin : g_mw
         $error("modem status must fill one register");
      end
      if (ADDR_W != REG_AW) begin : g_aw
         $error("address width mismatch");
      end
   endgenerate

   logic [IE_W-1:0]   ier_q;
   logic [MC_W-1:0]   mcr_q;
   logic [LS_W-1:0]   lsr_w;
   logic [DATA_W-1:0] rbuf_w, msr_w, iir_val;
   logic [NSRC-1:0]   req, grant;
   logic [IW-1:0]     idx;
   logic [1:0]        code;
   logic              any, thr_evt, loop, clr_thr;

   wire rd = cpu_sel & ~cpu_wr;
   wire wr = cpu_sel &  cpu_wr;

   assign loop = mcr_q[MC_LOOP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q <= '0;
         mcr_q <= '0;
      end else if (wr) begin
         if (cpu_addr == OFS_IEN)  ier_q <= cpu_wdata[IE_W-1:0];
         if (cpu_addr == OFS_MCTL) mcr_q <= cpu_wdata[MC_W-1:0];
      end
   end

   ust_line #(.DW(DATA_W)) line_i (
      .clk(clk), .rst_n(rst_n), .loop(loop),
      .wr_data(wr && cpu_addr == OFS_DATA), .rd_data(rd && cpu_addr == OFS_DATA),
      .wr_lst(wr && cpu_addr == OFS_LST),   .rd_lst(rd && cpu_addr == OFS_LST),
      .wdata(cpu_wdata), .clr_thr(clr_thr),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
      .rx_ferr(rx_ferr), .rx_brk(rx_brk), .tx_ready(tx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .rbuf(rbuf_w),
      .lst(lsr_w), .thr_evt(thr_evt)
   );

   ust_modem #(.MW(MDM_W), .RI_BIT(2)) modem_i (
      .clk(clk), .rst_n(rst_n), .loop(loop), .pins(modem_in),
      .wr_mst(wr && cpu_addr == OFS_MST), .rd_mst(rd && cpu_addr == OFS_MST),
      .wdata(cpu_wdata), .mst(msr_w)
   );

   assign req[SLOT_LN] = ier_q[IE_LINE] & (|lsr_w[LS_BI:LS_OE]);
   assign req[SLOT_RX] = ier_q[IE_RXD]  & lsr_w[LS_DR];
   assign req[SLOT_TH] = ier_q[IE_THR]  & thr_evt;
   assign req[SLOT_MD] = ier_q[IE_MDM]  & (|msr_w[MDM_W-1:0]);

   ust_prio #(.N(NSRC)) prio_i (.req(req), .grant(grant), .idx(idx), .any(any));

   assign code    = 2'(NSRC - 1) - 2'(idx);
   assign clr_thr = rd && cpu_addr == OFS_IID && grant[SLOT_TH];

   always_comb begin
      iir_val      = '0;
      iir_val[2:1] = any ? code : 2'b00;
      iir_val[0]   = ~any;
   end

   always_comb begin
      unique case (cpu_addr)
         OFS_DATA: cpu_rdata = rbuf_w;
         OFS_IEN:  cpu_rdata = DATA_W'(ier_q);
         OFS_IID:  cpu_rdata = iir_val;
         OFS_MCTL: cpu_rdata = DATA_W'(mcr_q);
         OFS_LST:  cpu_rdata = DATA_W'(lsr_w);
         OFS_MST:  cpu_rdata = msr_w;
         default:  cpu_rdata = '0;
      endcase
   end

   assign dtr_o = mcr_q[MC_DTR] & ~loop;
   assign rts_o = mcr_q[MC_RTS] & ~loop;
   assign irq_o = any & mcr_q[MC_OUT2] & ~loop;
endmodule

// File: rtl/ust_chk.sv
module ust_chk
   import ust_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            cpu_sel,
   input logic            cpu_wr,
   input logic [2:0]      cpu_addr,
   input logic [7:0]      cpu_wdata,
   input logic            tx_valid,
   input logic            irq_o,
   input logic            loop,
   input logic            out2,
   input logic [7:0]      iir_val,
   input logic [LS_W-1:0] lsr_w,
   input logic [IE_W-1:0] ier_q,
   input logic [NSRC-1:0] grant
);
   // R12
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (out2 && !loop && !iir_val[0]));

   // R2
   loop_tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop |-> !tx_valid);

   // R9
   lsr_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_sel && cpu_wr && cpu_addr == OFS_LST && loop)
      |=> (lsr_w == $past(cpu_wdata[LS_W-1:0])));

   // R6
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R6
   rx_over_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_w[LS_DR] && ier_q[IE_RXD] && !(ier_q[IE_LINE] && |lsr_w[LS_BI:LS_OE]))
      |-> (iir_val[2:0] == 3'b100));
endmodule

bind uart_selftest_ctrl ust_chk chk_i (
   .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
   .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .tx_valid(tx_valid),
   .irq_o(irq_o), .loop(mcr_q[4]), .out2(mcr_q[3]), .iir_val(iir_val),
   .lsr_w(lsr_w), .ier_q(ier_q), .grant(grant)
);

// File: tb/uart_selftest_ctrl_tb_top.sv
module uart_selftest_ctrl_tb_top;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cpu_sel = 0, cpu_wr = 0, tx_ready = 0, rx_valid = 0;
   logic       rx_perr = 0, rx_ferr = 0, rx_brk = 0;
   logic [2:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0, rx_data = '0, cpu_rdata, tx_data;
   logic [3:0] modem_in = '0;
   logic       tx_valid, dtr_o, rts_o, irq_o;
   int         checks = 0, errors = 0;
   logic [7:0] rv;

   always #5 clk = ~clk;

   uart_selftest_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
      .rx_ferr(rx_ferr), .rx_brk(rx_brk), .modem_in(modem_in),
      .dtr_o(dtr_o), .rts_o(rts_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_sel = 0; cpu_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_sel = 0;
   endtask

   task automatic rx_byte(input logic [7:0] d, input logic pe);
      @(negedge clk);
      rx_valid = 1; rx_data = d; rx_perr = pe;
      @(negedge clk);
      rx_valid = 0; rx_perr = 0;
   endtask

   function automatic logic [7:0] exp_iir(input logic [3:0] ie, input logic [5:0] ls,
                                          input logic flag, input logic [7:0] ms);
      if (ie[2] && |ls[4:1])      return 8'h06;
      else if (ie[0] && ls[0])    return 8'h04;
      else if (ie[1] && flag)     return 8'h02;
      else if (ie[3] && |ms[3:0]) return 8'h00;
      else                        return 8'h01;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=0x00 expected=0x01");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [3:0] ie_m;
      logic [5:0] ls_m;
      logic [7:0] ms_m, e;
      logic       fl_m;
      void'($urandom(32'h5EED_0A11));
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      rd(3'd2, rv); chk("R1 iid", rv, 8'h01);
      rd(3'd4, rv); chk("R1 lst", rv, 8'h20);
      rd(3'd1, rv); chk("R1 ien", rv, 8'h00);
      rd(3'd3, rv); chk("R1 mctl", rv, 8'h00);
      chk("R1 irq", {7'b0, irq_o}, 8'h00);
      chk("R1 txv", {7'b0, tx_valid}, 8'h00);

      // R11 status writes ignored outside loopback
      wr(3'd1, 8'h0F);
      wr(3'd4, 8'h1F);
      rd(3'd4, rv); chk("R11 lst", rv, 8'h20);
      wr(3'd5, 8'hFF);
      rd(3'd5, rv); chk("R11 mst", rv, 8'h00);
      rd(3'd2, rv); chk("R11 iid", rv, 8'h01);

      // R4 R7 R12 transmit path
      wr(3'd3, 8'h0B);
      wr(3'd1, 8'h02);
      wr(3'd0, 8'h3C);
      chk("R4 txv", {7'b0, tx_valid}, 8'h01);
      chk("R4 txd", tx_data, 8'h3C);
      chk("R2 dtr", {6'b0, rts_o, dtr_o}, 8'h03);
      rd(3'd4, rv); chk("R4 thre low", rv, 8'h00);
      @(negedge clk); tx_ready = 1;
      @(negedge clk); tx_ready = 0;
      chk("R4 txv done", {7'b0, tx_valid}, 8'h00);
      chk("R12 irq", {7'b0, irq_o}, 8'h01);
      rd(3'd2, rv); chk("R7 iid thr", rv, 8'h02);
      rd(3'd2, rv); chk("R7 iid cleared", rv, 8'h01);
      chk("R12 irq off", {7'b0, irq_o}, 8'h00);

      // R3 R5 R6 receive path
      wr(3'd1, 8'h05);
      rx_byte(8'h55, 0);
      rd(3'd2, rv); chk("R5 iid rx", rv, 8'h04);
      rx_byte(8'h66, 0);
      rd(3'd2, rv); chk("R6 iid line over rx", rv, 8'h06);
      rd(3'd4, rv); chk("R3 lst overrun", rv, 8'h23);
      rd(3'd2, rv); chk("R3 iid after lst read", rv, 8'h04);
      rd(3'd0, rv); chk("R3 data", rv, 8'h66);
      rd(3'd2, rv); chk("R3 dr cleared", rv, 8'h01);
      rx_byte(8'h77, 1);
      rd(3'd4, rv); chk("R3 lst parity", rv, 8'h25);
      rd(3'd0, rv); chk("R3 data pe", rv, 8'h77);

      // R8 modem status
      wr(3'd1, 8'h08);
      @(negedge clk); modem_in = 4'b0001;
      rd(3'd2, rv); chk("R8 iid mdm", rv, 8'h00);
      rd(3'd5, rv); chk("R8 mst cts", rv, 8'h11);
      rd(3'd5, rv); chk("R8 mst clr", rv, 8'h10);
      @(negedge clk); modem_in = 4'b0101;
      rd(3'd5, rv); chk("R8 ring rise", rv, 8'h50);
      @(negedge clk); modem_in = 4'b0001;
      rd(3'd5, rv); chk("R8 ring fall", rv, 8'h14);
      rd(3'd2, rv); chk("R8 iid idle", rv, 8'h01);

      // R2 loopback echo
      wr(3'd3, 8'h1B);
      wr(3'd1, 8'h01);
      chk("R2 pins", {6'b0, rts_o, dtr_o}, 8'h00);
      wr(3'd0, 8'hA5);
      chk("R2 txv", {7'b0, tx_valid}, 8'h00);
      rx_byte(8'h99, 1);
      rd(3'd4, rv); chk("R2 lst", rv, 8'h21);
      rd(3'd2, rv); chk("R2 iid", rv, 8'h04);
      chk("R12 irq loop", {7'b0, irq_o}, 8'h00);
      rd(3'd0, rv); chk("R2 echo", rv, 8'hA5);
      @(negedge clk); modem_in = 4'b1110;
      rd(3'd5, rv); chk("R2 pins ignored", rv, 8'h10);

      // R9 line status injection
      wr(3'd1, 8'h04);
      wr(3'd4, 8'h02);
      rd(3'd2, rv); chk("R9 iid", rv, 8'h06);
      rd(3'd4, rv); chk("R9 lst", rv, 8'h02);
      rd(3'd2, rv); chk("R9 serviced", rv, 8'h01);

      // R10 modem injection
      wr(3'd1, 8'h08);
      wr(3'd5, 8'h08);
      rd(3'd2, rv); chk("R10 iid", rv, 8'h00);
      rd(3'd5, rv); chk("R10 mst", rv, 8'h08);
      rd(3'd2, rv); chk("R10 serviced", rv, 8'h01);

      // R5 R6 R7 R9 R10 random injections in loopback
      wr(3'd4, 8'h00); wr(3'd5, 8'h00);
      ls_m = '0; ms_m = '0; fl_m = 0; ie_m = '0;
      for (int it = 0; it < 150; it++) begin
         ie_m = 4'($urandom % 16);
         wr(3'd1, {4'b0, ie_m});
         if ($urandom % 2 == 1) begin
            logic [5:0] v;
            v = 6'($urandom % 64);
            wr(3'd4, {2'b0, v});
            if (!v[5]) fl_m = 0; else if (!ls_m[5]) fl_m = 1;
            ls_m = v;
         end
         if ($urandom % 2 == 1) begin
            ms_m = 8'($urandom % 256);
            wr(3'd5, ms_m);
         end
         e = exp_iir(ie_m, ls_m, fl_m, ms_m);
         rd(3'd2, rv); chk("R6 random iid", rv, e);
         if (e == 8'h02) fl_m = 0;
         if ($urandom % 4 == 0) begin
            rd(3'd4, rv); chk("R9 random lst", rv, {2'b0, ls_m});
            ls_m[4:1] = '0;
         end
         if ($urandom % 4 == 0) begin
            rd(3'd5, rv); chk("R10 random mst", rv, ms_m);
            ms_m[3:0] = '0;
         end
         if (it % 16 == 0) chk("R12 random irq", {7'b0, irq_o}, 8'h00);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule